// File: doc/BRIEF.md
# Flash Page Program Loader

This block gathers the data of one flash page-program transaction from a serial command stream and hands it to the memory array as a sequence of merged byte writes. The stream arrives one bit per strobe, most significant bit first, framed by an active-low chip select. The first byte is the opcode. The next three bytes carry the target address. Every byte after that is program data. The data is placed in a page-sized buffer, starting at the column named by the low address byte and advancing one column per byte. Each column also keeps a flag that marks whether it was loaded.

When chip select is released, the block checks the transaction. The opcode must be the program code, at least one whole data byte must have arrived, the bit count must end on a byte boundary, write enable must be set, and no earlier commit may still be running. If all of these hold, the block scans the page one column per cycle. For every loaded column it presents a write to the array. The written value is the array's current byte ANDed with the loaded byte, so a bit can only go from one to zero. A busy flag covers the scan and a further programmable settling period that stands for the self-timed program time. The surrounding logic handles protection and maintains write enable.

Top module: `flash_page_loader`

## Requirements
- R1: After reset, `busy` and `cm_we` are low.
- R2: A transaction is the opcode byte 02h, then three address bytes, most significant byte first, with bits shifted in most significant bit first. Address bits 17..8 select the page and bits 7..0 select the starting column. Address bits 23..18 are ignored.
- R3: Data byte k is loaded into column (start + k) mod 256. The commit writes exactly once to each loaded column, at `cm_addr` = {page, column}. Columns that were not loaded are never written.
- R4: The column position wraps from FFh to 00h and stays inside the same page.
- R5: When more than 256 data bytes are sent, each column keeps the last byte loaded into it, so only the final 256 bytes are programmed.
- R6: If chip select rises while the bit count since the last byte boundary is nonzero, nothing is committed and `busy` stays low.
- R7: Nothing is committed if write enable is low when chip select rises, if the opcode is not 02h, or if no data byte followed the address.
- R8: Each commit write drives `cm_wdata` = `cm_rdata` AND loaded byte.
- R9: After a valid release of chip select, `busy` is high for exactly 2^COL_W + BUSY_CYCLES consecutive cycles. The first cycle is the one that follows the clock edge at which the release is seen.
- R10: A transaction whose chip select falls while `busy` is high is ignored entirely. It produces no writes and does not disturb the commit in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low transaction frame, synchronous to clk |
| bit_stb | input | 1 | One-cycle strobe that accepts `sdi` as the next bit |
| sdi | input | 1 | Serial data bit |
| wen | input | 1 | Write enable level, sampled when chip select rises |
| cm_rdata | input | 8 | Current array byte at `cm_addr` (combinational read) |
| cm_we | output | 1 | Array write strobe for a loaded column |
| cm_addr | output | ADDR_W | Array address {page, column} during the scan |
| cm_wdata | output | 8 | Merged byte written to the array |
| busy | output | 1 | Commit scan or settling period in progress |

## Verification
The main function is driven with a short load in the middle of a page whose upper address bits are junk, a full page from column zero, a load that crosses the top column, a 300-byte overrun, and a second program onto columns that were already programmed. Together these separate start-column handling, wrap, last-writer-wins, and the AND merge, because the array is preset with a mixed bit pattern. Rejection patterns cover a release after 5 and after 7 extra bits, write enable low, a wrong opcode, an address with no data, and a transaction started during the busy window. Each of these must leave the array untouched and must not add any busy cycles. Every array byte in four pages is compared against a model that is computed arithmetically, and the bench also counts writes and busy cycles.

// File: rtl/fpl_pkg.sv
package fpl_pkg;

  typedef enum logic [1:0] {
    PH_OPCODE = 2'd0,
    PH_ADDR   = 2'd1,
    PH_DATA   = 2'd2
  } fpl_phase_e;

  localparam logic [7:0] FPL_PROG_OP = 8'h02;

  // flash semantics: a program pass can only pull bits from one to zero
  function automatic logic [7:0] fpl_merge(input logic [7:0] old_b, input logic [7:0] new_b);
    return old_b & new_b;
  endfunction

endpackage

// File: rtl/fpl_bit_rx.sv
module fpl_bit_rx (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       bit_stb,
  input  logic       sdi,
  output logic       byte_stb,
  output logic [7:0] byte_val,
  output logic       partial
);

  logic [6:0] shreg;
  logic [2:0] bcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      bcnt  <= '0;
    end else if (cs_n) begin
      bcnt  <= '0;
    end else if (bit_stb) begin
      shreg <= {shreg[5:0], sdi};
      bcnt  <= bcnt + 3'd1;
    end
  end

  // the eighth bit completes a byte in the same cycle it is strobed
  assign byte_stb = bit_stb & ~cs_n & (bcnt == 3'd7);
  assign byte_val = {shreg, sdi};
  assign partial  = (bcnt != 3'd0);

  // R6: framing restarts at zero once the frame is closed
  a_r6_frame_restart: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !partial);

endmodule

// File: rtl/fpl_cmd_ctl.sv
module fpl_cmd_ctl
  import fpl_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int COL_W  = 8,
  localparam int PAGE_W = ADDR_W - COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_fall,
  input  logic              byte_stb,
  input  logic [7:0]        byte_val,
  input  logic              busy,
  output logic              data_we,
  output logic [COL_W-1:0]  data_col,
  output logic [7:0]        data_byte,
  output logic              clear_valid,
  output logic              load_ok,
  output logic [PAGE_W-1:0] page
);

  fpl_phase_e       phase;
  logic [1:0]       adr_cnt;
  logic             op_ok;
  logic             ign;
  logic             got_data;
  logic [ADDR_W-1:0] addr_sh;
  logic [COL_W-1:0] col;

  function automatic logic [COL_W-1:0] col_next(input logic [COL_W-1:0] c);
    return c + COL_W'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_OPCODE;
      adr_cnt  <= '0;
      op_ok    <= 1'b0;
      ign      <= 1'b0;
      got_data <= 1'b0;
      addr_sh  <= '0;
      col      <= '0;
    end else if (cs_fall) begin
      phase    <= PH_OPCODE;
      adr_cnt  <= '0;
      op_ok    <= 1'b0;
      ign      <= busy;
      got_data <= 1'b0;
    end else if (byte_stb) begin
      unique case (phase)
        PH_OPCODE: begin
          op_ok <= (byte_val == FPL_PROG_OP);
          phase <= PH_ADDR;
        end
        PH_ADDR: begin
          addr_sh <= {addr_sh[ADDR_W-9:0], byte_val};
          adr_cnt <= adr_cnt + 2'd1;
          if (adr_cnt == 2'd2) begin
            phase <= PH_DATA;
            col   <= byte_val[COL_W-1:0];
          end
        end
        default: begin
          if (op_ok && !ign) begin
            got_data <= 1'b1;
            col      <= col_next(col);
          end
        end
      endcase
    end
  end

  assign data_we     = byte_stb & (phase == PH_DATA) & op_ok & ~ign;
  assign data_col    = col;
  assign data_byte   = byte_val;
  assign clear_valid = cs_fall & ~busy;
  assign load_ok     = op_ok & got_data & ~ign & (phase == PH_DATA);
  assign page        = addr_sh[ADDR_W-1:COL_W];

  // R4: the top column is followed by column zero
  a_r4_col_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (data_we && col == '1) |=> (col == '0));

  // R2: the opcode byte always moves parsing on to the address
  a_r2_op_then_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_stb && phase == PH_OPCODE && !cs_fall) |=> (phase == PH_ADDR));

endmodule

// File: rtl/fpl_page_store.sv
module fpl_page_store #(
  parameter int COL_W = 8,
  localparam int PAGE = 1 << COL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_valid,
  input  logic             we,
  input  logic [COL_W-1:0] wcol,
  input  logic [7:0]       wbyte,
  input  logic [COL_W-1:0] rcol,
  output logic [7:0]       rbyte,
  output logic             rvalid
);

  logic [7:0]      mem [PAGE];
  logic [PAGE-1:0] vld;

  always_ff @(posedge clk) begin
    if (we) mem[wcol] <= wbyte;
  end

  for (genvar c = 0; c < PAGE; c++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              vld[c] <= 1'b0;
      else if (clear_valid)                    vld[c] <= 1'b0;
      else if (we && wcol == COL_W'(c))        vld[c] <= 1'b1;
    end
  end

  assign rbyte  = mem[rcol];
  assign rvalid = vld[rcol];

  // R3: a loaded column is marked for the commit scan
  a_r3_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !clear_valid) |=> vld[$past(wcol)]);

endmodule

// File: rtl/fpl_commit_seq.sv
module fpl_commit_seq
  import fpl_pkg::*;
#(
  parameter int ADDR_W      = 18,
  parameter int COL_W       = 8,
  parameter int BUSY_CYCLES = 4096,
  localparam int PAGE_W = ADDR_W - COL_W,
  localparam int TW     = $clog2(BUSY_CYCLES + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [PAGE_W-1:0] page_in,
  input  logic [7:0]        st_byte,
  input  logic              st_valid,
  input  logic [7:0]        cm_rdata,
  output logic [COL_W-1:0]  rcol,
  output logic              cm_we,
  output logic [ADDR_W-1:0] cm_addr,
  output logic [7:0]        cm_wdata,
  output logic              busy
);

  logic              scanning;
  logic [COL_W-1:0]  scol;
  logic [PAGE_W-1:0] page_q;
  logic [TW-1:0]     tmr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scanning <= 1'b0;
      scol     <= '0;
      page_q   <= '0;
      tmr      <= '0;
    end else if (go && !busy) begin
      scanning <= 1'b1;
      scol     <= '0;
      page_q   <= page_in;
    end else if (scanning) begin
      scol <= scol + COL_W'(1);
      if (scol == '1) begin
        scanning <= 1'b0;
        tmr      <= TW'(BUSY_CYCLES);
      end
    end else if (tmr != '0) begin
      tmr <= tmr - TW'(1);
    end
  end

  assign busy     = scanning | (tmr != '0);
  assign rcol     = scol;
  assign cm_we    = scanning & st_valid;
  assign cm_addr  = {page_q, scol};
  assign cm_wdata = fpl_merge(cm_rdata, st_byte);

  // R9: a started commit begins its scan at column zero
  a_r9_scan_start: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !busy) |=> (busy && cm_addr[COL_W-1:0] == '0));

  // R3: no array write outside the busy window
  a_r3_write_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    cm_we |-> busy);

  // R3: the page stays fixed for the whole scan
  a_r3_page_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (scanning && $past(scanning)) |-> $stable(cm_addr[ADDR_W-1:COL_W]));

endmodule

// File: rtl/flash_page_loader.sv
module flash_page_loader #(
  parameter int ADDR_W      = 18,
  parameter int COL_W       = 8,
  parameter int BUSY_CYCLES = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              bit_stb,
  input  logic              sdi,
  input  logic              wen,
  input  logic [7:0]        cm_rdata,
  output logic              cm_we,
  output logic [ADDR_W-1:0] cm_addr,
  output logic [7:0]        cm_wdata,
  output logic              busy
);

  localparam int PAGE_W = ADDR_W - COL_W;

  logic              cs_q;
  logic              cs_fall, cs_rise;
  logic              byte_stb, partial;
  logic [7:0]        byte_val;
  logic              data_we, clear_valid, load_ok;
  logic [COL_W-1:0]  data_col, rcol;
  logic [7:0]        data_byte, st_byte;
  logic              st_valid;
  logic [PAGE_W-1:0] page;
  logic              go;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cs_q <= 1'b1;
    else        cs_q <= cs_n;
  end

  assign cs_fall = cs_q & ~cs_n;
  assign cs_rise = ~cs_q & cs_n;

  fpl_bit_rx u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .bit_stb  (bit_stb),
    .sdi      (sdi),
    .byte_stb (byte_stb),
    .byte_val (byte_val),
    .partial  (partial)
  );

  fpl_cmd_ctl #(.ADDR_W(ADDR_W), .COL_W(COL_W)) u_ctl (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_fall     (cs_fall),
    .byte_stb    (byte_stb),
    .byte_val    (byte_val),
    .busy        (busy),
    .data_we     (data_we),
    .data_col    (data_col),
    .data_byte   (data_byte),
    .clear_valid (clear_valid),
    .load_ok     (load_ok),
    .page        (page)
  );

  fpl_page_store #(.COL_W(COL_W)) u_store (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear_valid (clear_valid),
    .we          (data_we),
    .wcol        (data_col),
    .wbyte       (data_byte),
    .rcol        (rcol),
    .rbyte       (st_byte),
    .rvalid      (st_valid)
  );

  // release decision: whole bytes only, write enable, a real load, not busy
  assign go = cs_rise & load_ok & ~partial & wen & ~busy;

  fpl_commit_seq #(.ADDR_W(ADDR_W), .COL_W(COL_W), .BUSY_CYCLES(BUSY_CYCLES)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (go),
    .page_in  (page),
    .st_byte  (st_byte),
    .st_valid (st_valid),
    .cm_rdata (cm_rdata),
    .rcol     (rcol),
    .cm_we    (cm_we),
    .cm_addr  (cm_addr),
    .cm_wdata (cm_wdata),
    .busy     (busy)
  );

  // R6: a release in the middle of a byte starts nothing
  a_r6_partial_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && partial && !busy) |=> !busy);

  // R7: a release without write enable starts nothing
  a_r7_needs_wen: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && !wen && !busy) |=> !busy);

  // R1: the array is never written while idle
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !cm_we);

endmodule

// File: tb/tb_flash_page_loader.sv
module tb_flash_page_loader;

  localparam int BUSYC = 32;
  localparam int PG    = 256;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic        bit_stb = 1'b0;
  logic        sdi = 1'b0;
  logic        wen = 1'b0;
  logic [7:0]  cm_rdata;
  logic        cm_we;
  logic [17:0] cm_addr;
  logic [7:0]  cm_wdata;
  logic        busy;

  always #10 clk = ~clk;

  flash_page_loader #(.ADDR_W(18), .COL_W(8), .BUSY_CYCLES(BUSYC)) dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .bit_stb(bit_stb), .sdi(sdi),
    .wen(wen), .cm_rdata(cm_rdata), .cm_we(cm_we), .cm_addr(cm_addr),
    .cm_wdata(cm_wdata), .busy(busy)
  );

  function automatic logic [7:0] init_fn(input int i);
    return 8'((i * 29) ^ 8'hB5);
  endfunction

  function automatic logic [7:0] dfn(input int seed, input int k);
    return 8'(seed * 7 + k * 13 + (k >> 8) * 91);
  endfunction

  // array model: four page slots selected by page bits 1..0
  logic [7:0] arr [0:1023];
  logic [7:0] ref_m [0:1023];
  int nvec = 0, nbad = 0;
  int wr_cnt = 0, busy_cnt = 0, addr_bad = 0;
  logic [9:0] exp_page = '0;

  assign cm_rdata = arr[{cm_addr[9:8], cm_addr[7:0]}];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 1024; i++) arr[i] <= init_fn(i);
    end else begin
      if (cm_we) begin
        arr[{cm_addr[9:8], cm_addr[7:0]}] <= cm_wdata;
        wr_cnt <= wr_cnt + 1;
        if (cm_addr[17:8] != exp_page) addr_bad <= addr_bad + 1;
      end
      if (busy) busy_cnt <= busy_cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sbit(input bit b);
    @(negedge clk); sdi = b; bit_stb = 1'b1;
    @(negedge clk); bit_stb = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) sbit(b[i]);
  endtask

  task automatic send_xfer(input logic [7:0] op, input logic [23:0] adr, input int n,
                           input int seed, input int xbits, input bit we_v,
                           output bit go_exp, output int exp_wr);
    bit         ld [PG];
    logic [7:0] nd [PG];
    logic [9:0] pg;
    bit         was_busy;
    pg = adr[17:8];
    exp_wr = 0;
    for (int c = 0; c < PG; c++) begin ld[c] = 1'b0; nd[c] = '0; end
    for (int k = 0; k < n; k++) begin
      int c;
      c = (int'(adr[7:0]) + k) % PG;
      ld[c] = 1'b1;
      nd[c] = dfn(seed, k);
    end
    @(negedge clk);
    wen = we_v;
    was_busy = busy;
    cs_n = 1'b0;
    @(negedge clk);
    send_byte(op);
    send_byte(adr[23:16]);
    send_byte(adr[15:8]);
    send_byte(adr[7:0]);
    for (int k = 0; k < n; k++) send_byte(dfn(seed, k));
    for (int b = 0; b < xbits; b++) sbit(b[0]);
    @(negedge clk);
    cs_n = 1'b1;
    go_exp = (op == 8'h02) && (n > 0) && (xbits == 0) && we_v && !was_busy;
    if (go_exp) begin
      exp_page = pg;
      for (int c = 0; c < PG; c++) if (ld[c]) begin
        exp_wr++;
        ref_m[{pg[1:0], 8'(c)}] = ref_m[{pg[1:0], 8'(c)}] & nd[c];
      end
    end
  endtask

  task automatic finish_xfer(input string req, input bit go_exp, input int exp_wr,
                             input int b_wr, input int b_busy, input int b_bad);
    int guard;
    repeat (3) @(negedge clk);
    guard = 0;
    while (busy && guard < 5000) begin @(negedge clk); guard++; end
    wen = 1'b0;
    @(negedge clk);
    chk(wr_cnt - b_wr == (go_exp ? exp_wr : 0), {req, " write count"},
        wr_cnt - b_wr, go_exp ? exp_wr : 0);
    chk(busy_cnt - b_busy == (go_exp ? PG + BUSYC : 0), {req, " R9 busy length"},
        busy_cnt - b_busy, go_exp ? PG + BUSYC : 0);
    chk(addr_bad == b_bad, {req, " R2 page address"}, addr_bad, b_bad);
    for (int i = 0; i < 1024; i++)
      chk(arr[i] == ref_m[i], {req, " R8 array byte"}, arr[i], ref_m[i]);
  endtask

  task automatic run(input string req, input logic [7:0] op, input logic [23:0] adr,
                     input int n, input int seed, input int xbits, input bit we_v);
    bit g; int e; int bw, bb, bd;
    bw = wr_cnt; bb = busy_cnt; bd = addr_bad;
    send_xfer(op, adr, n, seed, xbits, we_v, g, e);
    finish_xfer(req, g, e, bw, bb, bd);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    bit g1, g2; int e1, e2; int bw, bb, bd;
    for (int i = 0; i < 1024; i++) ref_m[i] = init_fn(i);
    repeat (5) @(negedge clk);
    // R1: reset state
    chk(busy == 1'b0, "R1 busy after reset", busy, 0);
    chk(cm_we == 1'b0, "R1 write strobe after reset", cm_we, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(busy == 1'b0 && cm_we == 1'b0, "R1 idle after release", busy, 0);

    // R2/R3: short load mid page, junk in the upper address bits
    run("R2 R3 short", 8'h02, 24'hFD0210, 4, 1, 0, 1'b1);
    // R3: full page from column zero
    run("R3 full", 8'h02, 24'h000000, 256, 2, 0, 1'b1);
    // R4: load crossing the top column
    run("R4 wrap", 8'h02, 24'h0101FA, 10, 3, 0, 1'b1);
    // R5: overrun, last 256 bytes win
    run("R5 overrun", 8'h02, 24'h03FF80, 300, 4, 0, 1'b1);
    // R8: second program onto the same columns
    run("R8 reprogram", 8'h02, 24'hFD0210, 4, 9, 0, 1'b1);
    // R6: release after a partial byte
    run("R6 partial5", 8'h02, 24'h000100, 3, 5, 5, 1'b1);
    run("R6 partial7", 8'h02, 24'h010220, 2, 6, 7, 1'b1);
    // R7: rejections
    run("R7 no wen", 8'h02, 24'h000030, 5, 7, 0, 1'b0);
    run("R7 bad opcode", 8'h03, 24'h000040, 5, 8, 0, 1'b1);
    run("R7 no data", 8'h02, 24'h000050, 0, 8, 0, 1'b1);

    // R10: second transaction started during the busy window
    bw = wr_cnt; bb = busy_cnt; bd = addr_bad;
    send_xfer(8'h02, 24'h000160, 6, 11, 0, 1'b1, g1, e1);
    repeat (3) @(negedge clk);
    chk(busy == 1'b1, "R10 busy before overlap", busy, 1);
    send_xfer(8'h02, 24'h000360, 2, 12, 0, 1'b1, g2, e2);
    chk(g2 == 1'b0, "R10 overlap not expected to commit", g2, 0);
    finish_xfer("R10 overlap", g1, e1, bw, bb, bd);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

endmodule